// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Replacement Unit

This block holds the replacement state of a four-way set-associative cache. Every set has three tree bits. The root bit picks between the way pair {A,B} and the pair {C,D}. One leaf bit picks between A and B, and the other picks between C and D. Each cache lookup that resolves to a way (a hit, or a fill into the chosen victim) reports the set index and a one-hot way vector on the update port. The set's tree bits are then rewritten so that they point away from the way just used.

A miss queries the victim for a set on the separate query port, which also takes the valid bits of that set's four ways. When every way is valid, the victim follows the tree bits. If any way is invalid, the lowest-numbered invalid way is returned instead. Empty ways are therefore filled before a valid line is evicted. The victim output is combinational from the stored bits, and an update takes effect at the next clock edge.

Each set behaves as an eight-state machine. Its state is the 3-bit value {L2,L1,L0}, where L0 is the pair-select root, L1 is the A/B leaf and L2 is the C/D leaf. There are four transitions, named TOUCH_A, TOUCH_B, TOUCH_C and TOUCH_D, one for each one-hot update.

Top module: `plru4_repl_unit`

## Requirements
- R1: After reset every set's tree bits are zero, so a query with all ways valid returns way A (index 0) for every set.
- R2: With all four ways valid, the victim is decided by the root bit L0. If L0 is 0, the victim is A (index 0) when L1 is 0 and B (index 1) when L1 is 1. If L0 is 1, the victim is C (index 2) when L2 is 0 and D (index 3) when L2 is 1.
- R3: TOUCH_A (update vector 4'b0001) writes L0=1 and L1=1 and keeps L2.
- R4: TOUCH_B (update vector 4'b0010) writes L0=1 and L1=0 and keeps L2. From state {L2,L1,L0}=000 this gives 001, and the victim of 001 is C.
- R5: TOUCH_C (update vector 4'b0100) writes L0=0 and L2=1 and keeps L1.
- R6: TOUCH_D (update vector 4'b1000) writes L0=0 and L2=0 and keeps L1.
- R7: An update is visible to queries from the clock edge that captures it onward. A query to the same set in the same cycle as the update sees the old bits.
- R8: If any bit of the query valid vector is 0, the victim is the lowest-numbered way whose valid bit is 0, whatever the tree bits are.
- R9: An update changes only the tree bits of its addressed set.
- R10: An update whose way vector is not exactly one-hot (zero, or two or more bits set) leaves all state unchanged.
- R11: The victim one-hot output has exactly one bit set, and that bit is the position given by the victim index output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Apply an access update this cycle |
| upd_set | input | SET_W | Set index of the update |
| upd_way_oh | input | 4 | One-hot way used (bit 0 = A ... bit 3 = D) |
| qry_set | input | SET_W | Set index of the victim query |
| qry_way_valid | input | 4 | Valid bits of the queried set's ways (bit i = way i) |
| victim_idx | output | 2 | Chosen way, 0=A, 1=B, 2=C, 3=D |
| victim_oh | output | 4 | Chosen way as one-hot |

## Verification
The victim outputs depend only on the query inputs and the stored bits, so they settle within the same cycle as the query. The bench drives the inputs just after a falling edge and compares the outputs 1 ns later, before the next rising edge. An update is due one rising edge after it is driven, so the bench's own per-set model advances only after the comparison in that cycle. This ordering makes same-cycle update-and-query cases expect the old victim. Directed steps walk each transition from known states, and a long pseudo-random sweep over a four-set configuration mixes one-hot, empty and multi-bit update vectors with every valid mask.

// File: rtl/plru4_pkg.sv
package plru4_pkg;

    typedef enum logic [1:0] {
        WAY_A = 2'd0,
        WAY_B = 2'd1,
        WAY_C = 2'd2,
        WAY_D = 2'd3
    } way_e;

    // Packed so that {L2,L1,L0} reads as the 3-bit set state
    typedef struct packed {
        logic cd_leaf;   // L2: 1 steers toward D, 0 toward C
        logic ab_leaf;   // L1: 1 steers toward B, 0 toward A
        logic pair_root; // L0: 1 steers toward {C,D}, 0 toward {A,B}
    } tree_t;

    localparam int unsigned NUM_WAYS = 4;
    localparam int unsigned TREE_W   = 3;

    function automatic way_e tree_victim(input tree_t t);
        way_e w;
        unique case ({t.pair_root, t.cd_leaf, t.ab_leaf})
            3'b000, 3'b010: w = WAY_A;
            3'b001, 3'b011: w = WAY_B;
            3'b100, 3'b101: w = WAY_C;
            3'b110, 3'b111: w = WAY_D;
            default:        w = WAY_A;
        endcase
        return w;
    endfunction

    function automatic tree_t tree_touch(input tree_t t, input way_e w);
        tree_t n;
        n = t;
        unique case (w)
            WAY_A: begin n.pair_root = 1'b1; n.ab_leaf = 1'b1; end
            WAY_B: begin n.pair_root = 1'b1; n.ab_leaf = 1'b0; end
            WAY_C: begin n.pair_root = 1'b0; n.cd_leaf = 1'b1; end
            WAY_D: begin n.pair_root = 1'b0; n.cd_leaf = 1'b0; end
            default: n = t;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/plru4_state_array.sv
module plru4_state_array
    import plru4_pkg::*;
#(
    parameter int unsigned NUM_SETS = 16,
    parameter int unsigned SET_W    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  tree_t                        wr_bits,
    input  logic [SET_W-1:0]             rd_q_set,
    output tree_t                        rd_q_bits,
    input  logic [SET_W-1:0]             rd_u_set,
    output tree_t                        rd_u_bits,
    output logic [NUM_SETS*TREE_W-1:0]   state_flat
);

    localparam int unsigned FLAT_W = NUM_SETS * TREE_W;

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        tree_t cell_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (wr_en && (wr_set == SET_W'(g))) begin
                cell_q <= wr_bits;
            end
        end

        assign state_flat[g*TREE_W +: TREE_W] = cell_q;
    end

    logic [FLAT_W-1:0] q_shift;
    logic [FLAT_W-1:0] u_shift;

    always_comb begin
        q_shift   = state_flat >> (rd_q_set * TREE_W);
        u_shift   = state_flat >> (rd_u_set * TREE_W);
        rd_q_bits = tree_t'(q_shift[TREE_W-1:0]);
        rd_u_bits = tree_t'(u_shift[TREE_W-1:0]);
    end

endmodule

// File: rtl/plru4_update.sv
module plru4_update
    import plru4_pkg::*;
(
    input  logic        upd_valid,
    input  logic [3:0]  hit_oh,
    input  tree_t       cur_bits,
    output logic        wr_en,
    output tree_t       new_bits
);

    way_e hit_way;
    logic hit_ok;

    always_comb begin
        hit_ok  = 1'b1;
        hit_way = WAY_A;
        unique case (hit_oh)
            4'b0001: hit_way = WAY_A;
            4'b0010: hit_way = WAY_B;
            4'b0100: hit_way = WAY_C;
            4'b1000: hit_way = WAY_D;
            default: hit_ok  = 1'b0;
        endcase
    end

    always_comb begin
        wr_en    = upd_valid && hit_ok;
        new_bits = tree_touch(cur_bits, hit_way);
    end

endmodule

// File: rtl/plru4_victim.sv
module plru4_victim
    import plru4_pkg::*;
(
    input  tree_t       tree_bits,
    input  logic [3:0]  way_valid,
    output logic [1:0]  victim_idx,
    output logic [3:0]  victim_oh
);

    way_e pick;

    always_comb begin
        pick = tree_victim(tree_bits);
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (!way_valid[i]) begin
                pick = way_e'(i[1:0]);
            end
        end
    end

    always_comb begin
        victim_idx = pick;
        victim_oh  = 4'b0001 << pick;
    end

endmodule

// File: rtl/plru4_repl_unit.sv
module plru4_repl_unit
    import plru4_pkg::*;
#(
    parameter int unsigned NUM_SETS = 16,
    localparam int unsigned SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [SET_W-1:0]  upd_set,
    input  logic [3:0]        upd_way_oh,
    input  logic [SET_W-1:0]  qry_set,
    input  logic [3:0]        qry_way_valid,
    output logic [1:0]        victim_idx,
    output logic [3:0]        victim_oh
);

    tree_t                        q_bits;
    tree_t                        u_bits;
    tree_t                        u_next;
    logic                         u_we;
    logic [NUM_SETS*TREE_W-1:0]   state_flat;

    plru4_state_array #(
        .NUM_SETS (NUM_SETS),
        .SET_W    (SET_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (u_we),
        .wr_set     (upd_set),
        .wr_bits    (u_next),
        .rd_q_set   (qry_set),
        .rd_q_bits  (q_bits),
        .rd_u_set   (upd_set),
        .rd_u_bits  (u_bits),
        .state_flat (state_flat)
    );

    plru4_update u_update (
        .upd_valid (upd_valid),
        .hit_oh    (upd_way_oh),
        .cur_bits  (u_bits),
        .wr_en     (u_we),
        .new_bits  (u_next)
    );

    plru4_victim u_victim (
        .tree_bits  (q_bits),
        .way_valid  (qry_way_valid),
        .victim_idx (victim_idx),
        .victim_oh  (victim_oh)
    );

endmodule

// File: rtl/plru4_repl_checker.sv
module plru4_repl_checker #(
    parameter int unsigned NUM_SETS = 16,
    parameter int unsigned SET_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd_valid,
    input  logic [SET_W-1:0]          upd_set,
    input  logic [3:0]                upd_way_oh,
    input  logic [3:0]                qry_way_valid,
    input  logic [1:0]                victim_idx,
    input  logic [3:0]                victim_oh,
    input  logic [NUM_SETS*3-1:0]     state_flat
);

    localparam int unsigned FW = NUM_SETS * 3;

    logic             primed_q;
    logic             last_v_q;
    logic [SET_W-1:0] last_set_q;
    logic [3:0]       last_oh_q;
    logic [2:0]       last_bits_q;
    logic [FW-1:0]    flat_q;
    logic [FW-1:0]    cur_shift;
    logic [FW-1:0]    aft_shift;
    logic [FW-1:0]    keep_mask;
    logic [2:0]       after_bits;

    always_comb begin
        cur_shift  = state_flat >> (upd_set * 3);
        aft_shift  = state_flat >> (last_set_q * 3);
        after_bits = aft_shift[2:0];
        keep_mask  = ~({{(FW-3){1'b0}}, 3'b111} << (last_set_q * 3));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q    <= 1'b0;
            last_v_q    <= 1'b0;
            last_set_q  <= '0;
            last_oh_q   <= '0;
            last_bits_q <= '0;
            flat_q      <= '0;
        end else begin
            primed_q    <= 1'b1;
            last_v_q    <= upd_valid;
            last_set_q  <= upd_set;
            last_oh_q   <= upd_way_oh;
            last_bits_q <= cur_shift[2:0];
            flat_q      <= state_flat;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !primed_q |-> (state_flat == '0));

    assert_touch_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && last_v_q && last_oh_q == 4'b0001) |->
        (after_bits[1:0] == 2'b11 && after_bits[2] == last_bits_q[2]));

    assert_touch_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && last_v_q && last_oh_q == 4'b0010) |->
        (after_bits[1:0] == 2'b01 && after_bits[2] == last_bits_q[2]));

    assert_touch_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && last_v_q && last_oh_q == 4'b0100) |->
        (after_bits[2] == 1'b1 && after_bits[0] == 1'b0 && after_bits[1] == last_bits_q[1]));

    assert_touch_d_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && last_v_q && last_oh_q == 4'b1000) |->
        (after_bits[2] == 1'b0 && after_bits[0] == 1'b0 && after_bits[1] == last_bits_q[1]));

    assert_other_sets_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> ((state_flat & keep_mask) == (flat_q & keep_mask)));

    assert_bad_vector_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $countones(last_oh_q) != 1) |-> (state_flat == flat_q));

    assert_invalid_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_way_valid != 4'hF) |->
        (((victim_oh & qry_way_valid) == 4'b0) && (((victim_oh - 4'd1) & ~qry_way_valid) == 4'b0)));

    assert_victim_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(victim_oh) == 1) && victim_oh[victim_idx]);

endmodule

bind plru4_repl_unit plru4_repl_checker #(
    .NUM_SETS (NUM_SETS),
    .SET_W    (SET_W)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .upd_valid     (upd_valid),
    .upd_set       (upd_set),
    .upd_way_oh    (upd_way_oh),
    .qry_way_valid (qry_way_valid),
    .victim_idx    (victim_idx),
    .victim_oh     (victim_oh),
    .state_flat    (state_flat)
);

// File: tb/plru4_repl_unit_bench.sv
`timescale 1ns/1ps
module plru4_repl_unit_bench;

    localparam int NSETS = 4;
    localparam int SW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_valid = 1'b0;
    logic [SW-1:0] upd_set = '0;
    logic [3:0]    upd_way_oh = '0;
    logic [SW-1:0] qry_set = '0;
    logic [3:0]    qry_way_valid = 4'hF;
    logic [1:0]    victim_idx;
    logic [3:0]    victim_oh;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // bench model: per set {L2,L1,L0}
    logic [2:0] mdl [NSETS];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    plru4_repl_unit #(.NUM_SETS(NSETS)) u_plru4_repl_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .upd_valid     (upd_valid),
        .upd_set       (upd_set),
        .upd_way_oh    (upd_way_oh),
        .qry_set       (qry_set),
        .qry_way_valid (qry_way_valid),
        .victim_idx    (victim_idx),
        .victim_oh     (victim_oh)
    );

    function automatic int exp_victim(input logic [2:0] b, input logic [3:0] vmask);
        for (int i = 0; i < 4; i++) begin
            if (!vmask[i]) return i;
        end
        if (b[0] == 1'b0) return b[1] ? 1 : 0;
        return b[2] ? 3 : 2;
    endfunction

    function automatic logic [2:0] touch(input logic [2:0] b, input int w);
        logic [2:0] n;
        n = b;
        case (w)
            0: begin n[0] = 1'b1; n[1] = 1'b1; end
            1: begin n[0] = 1'b1; n[1] = 1'b0; end
            2: begin n[0] = 1'b0; n[2] = 1'b1; end
            default: begin n[0] = 1'b0; n[2] = 1'b0; end
        endcase
        return n;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive, compare victim against model (old state), then advance model
    task automatic step(input logic uv, input int us, input logic [3:0] uoh,
                        input int qs, input logic [3:0] qm, input string tag);
        int e;
        @(negedge clk);
        upd_valid     = uv;
        upd_set       = SW'(us);
        upd_way_oh    = uoh;
        qry_set       = SW'(qs);
        qry_way_valid = qm;
        #1;
        e = exp_victim(mdl[qs], qm);
        check(tag, int'(victim_idx), e);
        check({tag, " R11 onehot"}, int'(victim_oh), 1 << e);
        if (uv && $countones(uoh) == 1) begin
            for (int w = 0; w < 4; w++) begin
                if (uoh[w]) mdl[us] = touch(mdl[us], w);
            end
        end
    endtask

    task automatic query_expect(input int qs, input int exp, input string tag);
        @(negedge clk);
        upd_valid     = 1'b0;
        upd_way_oh    = 4'b0;
        qry_set       = SW'(qs);
        qry_way_valid = 4'hF;
        #1;
        check(tag, int'(victim_idx), exp);
    endtask

    initial begin
        for (int s = 0; s < NSETS; s++) mdl[s] = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on every set
        for (int s = 0; s < NSETS; s++) query_expect(s, 0, "R1 reset victim A");

        // R4 stated example: 000 + hit B -> 001 -> victim C
        step(1'b1, 0, 4'b0010, 1, 4'hF, "R4 update B");
        query_expect(0, 2, "R4 state 001 victim C");

        // R3/R5/R6 walk on set 3
        step(1'b1, 3, 4'b0001, 2, 4'hF, "R3 update A");
        query_expect(3, 2, "R3 L0=1 L2 kept");
        step(1'b1, 3, 4'b0100, 2, 4'hF, "R5 update C");
        query_expect(3, 1, "R5 L0=0 L1 kept");
        step(1'b1, 3, 4'b1000, 2, 4'hF, "R6 update D");
        query_expect(3, 1, "R6 L0=0 L1 kept");
        step(1'b1, 3, 4'b0001, 2, 4'hF, "R3 update A again");
        step(1'b1, 3, 4'b0100, 2, 4'hF, "R5 update C again");
        step(1'b1, 3, 4'b0001, 2, 4'hF, "R3 setup");
        query_expect(3, 3, "R2 L0=1 L2=1 victim D");

        // R9: set 1 and set 2 untouched so far
        query_expect(1, 0, "R9 set 1 unchanged");
        query_expect(2, 0, "R9 set 2 unchanged");

        // R7: update and query same set in same cycle sees old state
        step(1'b1, 2, 4'b0001, 2, 4'hF, "R7 same-cycle old state");
        query_expect(2, 2, "R7 new state next cycle");

        // R10: bad vectors ignored (set 2 victim stays C)
        step(1'b1, 2, 4'b0000, 2, 4'hF, "R10 zero vector");
        query_expect(2, 2, "R10 zero vector ignored");
        step(1'b1, 2, 4'b0110, 2, 4'hF, "R10 multi vector");
        query_expect(2, 2, "R10 multi vector ignored");

        // R8: invalid ways chosen first
        step(1'b0, 0, 4'b0, 3, 4'b1011, "R8 way C invalid");
        step(1'b0, 0, 4'b0, 3, 4'b0110, "R8 ways A,D invalid");
        step(1'b0, 0, 4'b0, 3, 4'b0111, "R8 way D invalid");

        // Near-exhaustive sweep
        for (int k = 0; k < 6000; k++) begin
            logic [3:0] oh;
            logic [3:0] vm;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            oh = (lfsr[3:2] == 2'b00) ? lfsr[7:4] : (4'b0001 << lfsr[5:4]);
            vm = (lfsr[9:8] == 2'b00) ? lfsr[15:12] : 4'hF;
            step(lfsr[0] | lfsr[1], int'(lfsr[11:10]), oh, int'(lfsr[15:14]), vm,
                 (vm == 4'hF) ? "R2 sweep tree victim" : "R8 sweep invalid first");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

endmodule